// File: doc/BRIEF.md
# Serial Configuration Download Sequencer

This block sits on a host board and loads a setup bitstream into one or more configurable devices on a plug-in daughter card over a narrow serial link. It pulses an active-low program request and waits for the targets on the shared open-drain init line. Each target holds that line low while it prepares itself. The block then shifts the bitstream out as serial data with a serial clock, and it finishes when the shared open-drain done line returns high. A mode input picks how the active-low reset output behaves. In one mode it is combined with the program request, for targets that need that. In the other mode it is a separate user-controlled reset.

Bytes of the bitstream arrive on a valid/ready stream, and the last byte is marked. The block reports busy while a download is running. At the end it raises either a done flag or an error flag. The error flag means the init line was never released, or the done line did not rise within a fixed window after the last bit.

Top module: `cfg_loader`

## Requirements
- R1: After reset, prog_n_o and rst_n_o are 1, sclk_o is 0, and busy_o, done_o, error_o and byte_ready_o are 0.
- R2: A pulse on start_i while idle drives prog_n_o low for exactly PROG_CYCLES clock cycles, then returns it high.
- R3: No rising edge of sclk_o occurs until the init line (init_n_i) has first been seen low after the program pulse and then seen high again.
- R4: Each byte is sent most significant bit first. The bit is on sdata_o and is sampled by the target on the rising edge of sclk_o. sdata_o does not change while sclk_o is high.
- R5: Every high phase and every in-byte low phase of sclk_o lasts exactly CLK_DIV clock cycles.
- R6: After the byte marked with byte_last_i has been shifted, busy_o stays high until done_i is seen high. Then busy_o falls and done_o rises. done_o is never 1 while done_i is still low during a download.
- R7: If the init line has not gone low and back high within INIT_TIMEOUT cycles of the program pulse ending, error_o is set, busy_o falls, and no serial clock is produced. A later start clears error_o.
- R8: If done_i stays low for DONE_TIMEOUT cycles after the last bit, error_o is set and done_o stays 0.
- R9: With legacy_rst_i = 1, rst_n_o is low for exactly the PROG_CYCLES cycles of the program pulse and also whenever user_rst_i is 1.
- R10: With legacy_rst_i = 0, rst_n_o follows only user_rst_i (low one clock after user_rst_i is 1) and is unaffected by the program pulse.
- R11: byte_ready_o is high only while the block is waiting for a byte. Each transfer (byte_valid_i and byte_ready_o both high on a clock edge) takes exactly one byte, and no byte is taken while one is still being shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a download (taken when idle) |
| legacy_rst_i | input | 1 | 1: reset output combined with program request; 0: independent |
| user_rst_i | input | 1 | User reset request for the targets |
| byte_data_i | input | 8 | Bitstream byte |
| byte_last_i | input | 1 | Marks the final byte of the bitstream |
| byte_valid_i | input | 1 | Byte available |
| byte_ready_o | output | 1 | Block can take a byte |
| prog_n_o | output | 1 | Program request, active low |
| init_n_i | input | 1 | Wired-AND init line from the targets, low while busy |
| done_i | input | 1 | Wired-AND done line, high when all targets are loaded |
| sdata_o | output | 1 | Serial configuration data |
| sclk_o | output | 1 | Serial configuration clock |
| rst_n_o | output | 1 | Reset to the targets, active low |
| busy_o | output | 1 | Download in progress |
| done_o | output | 1 | Last download completed |
| error_o | output | 1 | Last download timed out |

## Verification
A model of the targets in the bench rebuilds bytes from the rising edges of the serial clock. Directed bytes 8'hA5, 8'h00, 8'hFF and 8'h80 show whether the bit order or shift direction is wrong and whether a bit gets stuck. Random streams of one to six bytes, with random init hold times, exercise the handshake between bytes and the wait on the init line. A stuck init line and a stuck done line each show whether the matching timeout fires. Running both reset modes shows whether the reset output is tied to the program pulse in one mode and kept apart from it in the other.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_WAIT_LOW,
    ST_WAIT_HIGH,
    ST_FETCH,
    ST_SHIFT,
    ST_WAIT_DONE
  } cfgl_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/cfgl_sync2.sv
module cfgl_sync2 #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      logic meta_q, sync_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
        end else begin
          meta_q <= d_i[gi];
          sync_q <= meta_q;
        end
      end
      assign q_o[gi] = sync_q;
    end
  endgenerate
endmodule

// File: rtl/cfgl_shifter.sv
module cfgl_shifter
  import cfgl_pkg::*;
#(
  parameter int unsigned CLK_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              fin_o
);
  localparam int unsigned DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shreg_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic              active_q;
  logic              half_end;

  assign half_end = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      div_q    <= '0;
      bit_q    <= '0;
      active_q <= 1'b0;
      sclk_o   <= 1'b0;
      sdata_o  <= 1'b0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (load_i) begin
        shreg_q  <= byte_i;
        sdata_o  <= byte_i[BYTE_W-1];
        div_q    <= '0;
        bit_q    <= '0;
        sclk_o   <= 1'b0;
        active_q <= 1'b1;
      end else if (active_q) begin
        if (half_end) begin
          div_q <= '0;
          if (!sclk_o) begin
            sclk_o <= 1'b1;
          end else begin
            sclk_o <= 1'b0;
            if (bit_q == BIT_W'(BYTE_W - 1)) begin
              active_q <= 1'b0;
              fin_o    <= 1'b1;
            end else begin
              bit_q   <= bit_q + 1'b1;
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              sdata_o <= shreg_q[BYTE_W-2];
            end
          end
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  // R4
  sdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  // R11
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active_q);
endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned INIT_TIMEOUT = 200,
  parameter int unsigned DONE_TIMEOUT = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic init_hi_i,
  input  logic done_hi_i,
  input  logic byte_valid_i,
  input  logic byte_last_i,
  input  logic shift_fin_i,
  output logic byte_ready_o,
  output logic load_o,
  output logic prog_n_o,
  output logic busy_o,
  output logic done_o,
  output logic error_o
);
  localparam int unsigned MAX_T = (PROG_CYCLES > INIT_TIMEOUT) ?
    ((PROG_CYCLES > DONE_TIMEOUT) ? PROG_CYCLES : DONE_TIMEOUT) :
    ((INIT_TIMEOUT > DONE_TIMEOUT) ? INIT_TIMEOUT : DONE_TIMEOUT);
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  cfgl_state_e      state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_q;

  assign byte_ready_o = (state_q == ST_FETCH);
  assign load_o       = byte_ready_o && byte_valid_i;
  assign busy_o       = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      last_q   <= 1'b0;
      prog_n_o <= 1'b1;
      done_o   <= 1'b0;
      error_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_PROG;
            cnt_q    <= '0;
            prog_n_o <= 1'b0;
            done_o   <= 1'b0;
            error_o  <= 1'b0;
          end
        end
        ST_PROG: begin
          if (cnt_q == CNT_W'(PROG_CYCLES - 1)) begin
            prog_n_o <= 1'b1;
            cnt_q    <= '0;
            state_q  <= ST_WAIT_LOW;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT_LOW, ST_WAIT_HIGH: begin
          if (cnt_q == CNT_W'(INIT_TIMEOUT - 1)) begin
            error_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_WAIT_LOW && !init_hi_i) state_q <= ST_WAIT_HIGH;
            if (state_q == ST_WAIT_HIGH && init_hi_i) state_q <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (byte_valid_i) begin
            last_q  <= byte_last_i;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_fin_i) begin
            cnt_q   <= '0;
            state_q <= last_q ? ST_WAIT_DONE : ST_FETCH;
          end
        end
        ST_WAIT_DONE: begin
          if (done_hi_i) begin
            done_o  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cnt_q == CNT_W'(DONE_TIMEOUT - 1)) begin
            error_o <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R6
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));

  // R6
  done_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(done_hi_i));

  // R2
  prog_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> busy_o);
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int unsigned CLK_DIV      = 2,
  parameter int unsigned PROG_CYCLES  = 8,
  parameter int unsigned INIT_TIMEOUT = 200,
  parameter int unsigned DONE_TIMEOUT = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       legacy_rst_i,
  input  logic       user_rst_i,
  input  logic [7:0] byte_data_i,
  input  logic       byte_last_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic       prog_n_o,
  input  logic       init_n_i,
  input  logic       done_i,
  output logic       sdata_o,
  output logic       sclk_o,
  output logic       rst_n_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       error_o
);
  logic [1:0] sync_q;
  logic       init_hi, done_hi;
  logic       load, fin;

  cfgl_sync2 #(.WIDTH(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({done_i, init_n_i}),
    .q_o (sync_q)
  );
  assign init_hi = sync_q[0];
  assign done_hi = sync_q[1];

  cfgl_ctrl #(
    .PROG_CYCLES  (PROG_CYCLES),
    .INIT_TIMEOUT (INIT_TIMEOUT),
    .DONE_TIMEOUT (DONE_TIMEOUT)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .init_hi_i    (init_hi),
    .done_hi_i    (done_hi),
    .byte_valid_i (byte_valid_i),
    .byte_last_i  (byte_last_i),
    .shift_fin_i  (fin),
    .byte_ready_o (byte_ready_o),
    .load_o       (load),
    .prog_n_o     (prog_n_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .error_o      (error_o)
  );

  cfgl_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .byte_i  (byte_data_i),
    .sdata_o (sdata_o),
    .sclk_o  (sclk_o),
    .fin_o   (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_n_o <= 1'b1;
    else     rst_n_o <= !(user_rst_i || (legacy_rst_i && !prog_n_o));
  end

  // R3
  clk_after_init_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> init_hi);

  // R10
  indep_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (!legacy_rst_i && !$past(user_rst_i) && !$past(legacy_rst_i)) |-> rst_n_o);
endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  localparam int CLK_DIV = 2;
  localparam int PROG    = 8;
  localparam int INIT_TO = 200;
  localparam int DONE_TO = 100;

  logic clk = 0;
  always #4 clk = ~clk;

  logic rst = 1, start = 0, legacy = 1, user_rst = 0;
  logic [7:0] byte_data;
  logic byte_last, byte_valid, byte_ready;
  logic prog_n, sdata, sclk, rst_n, busy, done, error;
  logic init_n, done_line;

  int checks = 0, failures = 0;

  logic [7:0] src_mem [0:7];
  int src_len = 0, idx = 0;
  bit src_en = 0, take = 0;
  assign byte_valid = src_en && (idx < src_len);
  assign byte_data  = src_mem[idx[2:0]];
  assign byte_last  = (idx == src_len - 1);

  // target model state
  int init_hold = 5;      // -1 : never release
  bit done_en = 1;
  bit init_low = 0;
  int init_cnt = 0;
  bit prev_prog = 1, prev_sclk = 0;
  logic [7:0] rx_shift;
  logic [7:0] rx_mem [0:7];
  int bits = 0, exp_bits = 0, done_cnt = 0;
  int early_clk = 0, hi_w = 0, hi_bad = 0, lo_w = 0, lo_bad = 0;
  int prog_low = 0, rst_low = 0, taken = 0, done_early = 0, ready_bad = 0;

  assign init_n = init_low ? 1'b0 : 1'b1;

  cfg_loader #(.CLK_DIV(CLK_DIV), .PROG_CYCLES(PROG), .INIT_TIMEOUT(INIT_TO),
               .DONE_TIMEOUT(DONE_TO)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .legacy_rst_i(legacy),
    .user_rst_i(user_rst), .byte_data_i(byte_data), .byte_last_i(byte_last),
    .byte_valid_i(byte_valid), .byte_ready_o(byte_ready), .prog_n_o(prog_n),
    .init_n_i(init_n), .done_i(done_line), .sdata_o(sdata), .sclk_o(sclk),
    .rst_n_o(rst_n), .busy_o(busy), .done_o(done), .error_o(error));

  always @(negedge clk) begin
    if (take) begin idx = idx + 1; taken = taken + 1; end
    take = byte_valid && byte_ready;
    if (byte_ready && sclk) ready_bad = ready_bad + 1;
    if (!prog_n) begin prog_low = prog_low + 1; done_line = 0; bits = 0; end
    if (!rst_n) rst_low = rst_low + 1;
    if (prog_n && !prev_prog) begin init_low = 1; init_cnt = init_hold; end
    else if (init_low && init_hold >= 0) begin
      if (init_cnt <= 0) init_low = 0; else init_cnt = init_cnt - 1;
    end
    if (sclk && !prev_sclk) begin
      if (init_low) early_clk = early_clk + 1;
      rx_shift = {rx_shift[6:0], sdata};
      bits = bits + 1;
      if (bits % 8 == 0) rx_mem[(bits/8 - 1) % 8] = rx_shift;
      if (lo_w != 0 && (bits % 8) != 1 && lo_w != CLK_DIV) lo_bad = lo_bad + 1;
      hi_w = 0;
    end
    if (sclk) hi_w = hi_w + 1;
    if (!sclk && prev_sclk && hi_w != CLK_DIV) hi_bad = hi_bad + 1;
    if (!sclk) lo_w = (prev_sclk ? 1 : lo_w + 1);
    if (done_en && !done_line && exp_bits > 0 && bits == exp_bits) begin
      done_cnt = done_cnt + 1;
      if (done_cnt >= 3) done_line = 1;
    end
    if (busy && done && !done_line) done_early = done_early + 1;
    prev_prog = prog_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic run(input int n, input int hold, input bit den, input bit leg);
    @(negedge clk);
    src_len = n; idx = 0; take = 0; src_en = 1;
    init_hold = hold; done_en = den; legacy = leg;
    exp_bits = den ? n * 8 : 0; done_cnt = 0;
    early_clk = 0; hi_bad = 0; lo_bad = 0; lo_w = 0; prog_low = 0; rst_low = 0;
    taken = 0; done_early = 0; ready_bad = 0; bits = 0;
    for (int i = 0; i < 8; i++) rx_mem[i] = 8'hxx;
    start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 5000 && busy; c++) @(negedge clk);
    src_en = 0;
    @(negedge clk);
  endtask

  function automatic logic [7:0] rbyte();
    return 8'($urandom);
  endfunction

  task automatic check_ok(input int n, input bit leg);
    chk(!busy && done && !error, "R6 done", {busy, done, error}, 3'b010);
    chk(done_early == 0, "R6 early done", done_early, 0);
    chk(prog_low == PROG, "R2 prog width", prog_low, PROG);
    chk(early_clk == 0, "R3 clock before init", early_clk, 0);
    chk(hi_bad == 0 && lo_bad == 0, "R5 sclk phases", hi_bad + lo_bad, 0);
    chk(taken == n && ready_bad == 0, "R11 bytes taken", taken, n);
    for (int i = 0; i < n; i++)
      chk(rx_mem[i] === src_mem[i], "R4 byte", int'(rx_mem[i]), int'(src_mem[i]));
    if (leg) chk(rst_low == PROG, "R9 legacy reset width", rst_low, PROG);
    else     chk(rst_low == 0, "R10 independent reset", rst_low, 0);
  endtask

  initial begin
    #1600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    done_line = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(prog_n && rst_n && !sclk && !busy && !done && !error && !byte_ready,
        "R1 reset state", {prog_n, rst_n, sclk, busy, done, error, byte_ready}, 7'b1100000);

    src_mem[0] = 8'hA5;
    run(1, 6, 1, 1); check_ok(1, 1);

    src_mem[0] = 8'h00; src_mem[1] = 8'hFF; src_mem[2] = 8'h80; src_mem[3] = 8'h01;
    run(4, 0, 1, 0); check_ok(4, 0);

    for (int r = 0; r < 6; r++) begin
      int n = 1 + ($urandom % 6);
      bit leg = 1'($urandom);
      for (int i = 0; i < n; i++) src_mem[i] = rbyte();
      run(n, 2 + ($urandom % 40), 1, leg);
      check_ok(n, leg);
    end

    // R7 init never released
    src_mem[0] = 8'h3C;
    run(1, -1, 1, 1);
    chk(error && !done && !busy, "R7 init timeout", {error, done, busy}, 3'b100);
    chk(bits == 0, "R7 no serial clock", bits, 0);
    // R7 later start clears error
    run(1, 4, 1, 1);
    chk(!error && done, "R7 error cleared", {error, done}, 2'b01);

    // R8 done never rises
    src_mem[0] = 8'h5A; src_mem[1] = 8'hC3;
    run(2, 4, 0, 1);
    chk(error && !done, "R8 done timeout", {error, done}, 2'b10);
    chk(rx_mem[1] === 8'hC3, "R8 bits still sent", int'(rx_mem[1]), 8'hC3);

    // R9 / R10 user reset in both modes
    legacy = 0; user_rst = 1;
    @(negedge clk);
    chk(!rst_n, "R10 user reset", rst_n, 0);
    user_rst = 0;
    @(negedge clk);
    chk(rst_n, "R10 user reset release", rst_n, 1);
    legacy = 1; user_rst = 1;
    @(negedge clk);
    chk(!rst_n, "R9 user reset legacy", rst_n, 0);
    user_rst = 0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule